// File: doc/BRIEF.md
# NAND Flash Host Bridge

This block lets a host processor run an 8-bit NAND flash device through a small window of byte registers. The host writes a mode byte that chooses the bus phase (command, address or plain data) and switches the chip enable, the write-protect release and the flash power switch. Accesses to the data register at offset 0 then turn into NAND byte cycles. An 8-bit access makes one cycle. A 16-bit access makes two cycles, with the low byte first. The block generates the write and read strobes itself, each low for a fixed number of clocks and followed by a fixed recovery time.

The ready/busy line of the flash is synchronised and shown in a status register. A rising edge on that line, which marks the end of a busy period, latches a ready event into an interrupt status register. That event reaches the interrupt output only when the mask register enables it. The host clears status bits by writing ones to them.

The host port is valid/ready. A request is taken in the cycle where `host_req_valid` and `host_req_ready` are both high. `host_req_ready` stays low while a NAND byte sequence is running, so the host must hold its request until it is taken. Every accepted request returns exactly one `host_rsp_valid` pulse. Responses cannot be stalled: the host must be able to take one in any cycle.

Top module: `nand_bridge`

## Requirements
- R1: After reset, chip enable is inactive (`nand_ce_n`=1), CLE, ALE, the power switch, the write-protect release and `irq` are 0, both strobes are high, and the mode register (offset 4) reads 0x00.
- R2: The mode register drives the pins directly: bit 4 set gives `nand_ce_n`=0, bit 0 drives `nand_cle`, bit 1 drives `nand_ale` and bit 7 drives `nand_wp_n`. Value 0x95 is the command phase, 0x96 the address phase, 0x94 the data phase with both latches low, and 0x00 is standby with chip enable off.
- R3: Mode bit 2 drives `nand_pwr_en`. Writing 0x0C turns the power switch on and writing 0x08 turns it off.
- R4: An 8-bit host write to offset 0 makes exactly one write strobe. `nand_we_n` is low for PULSE_CYC clocks and `nand_dq_out` holds the written byte.
- R5: A 16-bit host write to offset 0 makes two write strobes of PULSE_CYC clocks, with bits 7:0 first and then bits 15:8. `host_req_ready` is low from the cycle after acceptance until the sequence is done.
- R6: A 16-bit host read of offset 0 makes two read strobes of PULSE_CYC clocks. The byte from the first strobe is returned in bits 7:0 and the byte from the second in bits 15:8.
- R7: An 8-bit host read of offset 0 makes one read strobe and returns the byte in bits 7:0, with bits 15:8 set to zero.
- R8: Status register bit 7 (offset 5) reads 1 while `nand_rb_n` is low (busy) and 0 while it is high. The line passes through SYNC_STAGES flops first.
- R9: Interrupt status bit 0 (offset 6) is set by a rising edge of the synchronised `nand_rb_n` and not by a falling edge. Writing a 1 to a status bit clears it, so writing 0x0F clears all four bits.
- R10: `irq` is high exactly when some interrupt status bit and the mask bit at the same position (offset 7, low four bits) are both 1. Mask 0x81 enables the ready event and mask 0x00 blocks it.
- R11: At most one strobe is low at any time, and `nand_dq_oe` is high whenever `nand_we_n` is low.
- R12: A register access is answered with `host_rsp_valid` in the cycle right after it is accepted. Reads of offsets 4 and 7 return the value last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Bridge can take a request |
| host_req_write | input | 1 | 1 for a write, 0 for a read |
| host_req_addr | input | 3 | Register offset |
| host_req_wide | input | 1 | 1 for a 16-bit access, 0 for an 8-bit access |
| host_req_wdata | input | 16 | Write data |
| host_rsp_valid | output | 1 | One-cycle response pulse |
| host_rsp_rdata | output | 16 | Read data, valid with the response |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write-protect release (mode bit 7) |
| nand_pwr_en | output | 1 | Flash power switch |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte read from the flash |
| nand_rb_n | input | 1 | Ready/busy from the flash, low while busy |
| irq | output | 1 | Ready interrupt |

## Verification
The bench builds the bridge with PULSE_CYC=3, RECOVER_CYC=2 and SYNC_STAGES=2. With a strobe of more than one clock, the bench can catch a strobe that is one clock short or long, and a recovery gap of two clocks keeps the two strobes of a 16-bit access clearly apart in the pulse monitor. With a short synchroniser, the busy bit and the ready event appear within a few clocks of a change on the ready/busy line. The bench can therefore check both polarities of that line and the write-one-to-clear sequence quickly, between bursts of random 8-bit and 16-bit data traffic.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam int HOST_AW = 3;
  localparam int NAND_DW = 8;
  localparam int HOST_DW = 16;

  localparam logic [HOST_AW-1:0] OFS_DATA = 3'd0;
  localparam logic [HOST_AW-1:0] OFS_MODE = 3'd4;
  localparam logic [HOST_AW-1:0] OFS_STAT = 3'd5;
  localparam logic [HOST_AW-1:0] OFS_ISR  = 3'd6;
  localparam logic [HOST_AW-1:0] OFS_IMR  = 3'd7;

  localparam int MB_WP  = 7;
  localparam int MB_CE  = 4;
  localparam int MB_PWR = 2;
  localparam int MB_ALE = 1;
  localparam int MB_CLE = 0;

  localparam int ST_BUSY_BIT = 7;
  localparam int EV_READY    = 0;
  localparam int EV_BITS     = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } strobe_ph_e;
endpackage

// File: rtl/nand_bridge_sync.sv
module nand_bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] chain;

  generate
    for (genvar g = 0; g < LEN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs
  import nand_bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [HOST_AW-1:0] addr,
  input  logic [7:0]         wdata,
  input  logic               rdy_rise,
  input  logic               busy,
  output logic [7:0]         mode,
  output logic [EV_BITS-1:0] isr,
  output logic [7:0]         imr,
  output logic [7:0]         rd_byte,
  output logic               irq
);
  logic [EV_BITS-1:0] ev_set;

  always_comb begin
    ev_set = '0;
    ev_set[EV_READY] = rdy_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      imr  <= '0;
    end else if (wr_en) begin
      if (addr == OFS_MODE) mode <= wdata;
      if (addr == OFS_IMR)  imr  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= '0;
    end else if (wr_en && addr == OFS_ISR) begin
      isr <= (isr & ~wdata[EV_BITS-1:0]) | ev_set;
    end else begin
      isr <= isr | ev_set;
    end
  end

  always_comb begin
    rd_byte = '0;
    case (addr)
      OFS_MODE: rd_byte = mode;
      OFS_STAT: rd_byte[ST_BUSY_BIT] = busy;
      OFS_ISR:  rd_byte[EV_BITS-1:0] = isr;
      OFS_IMR:  rd_byte = imr;
      default:  rd_byte = '0;
    endcase
  end

  assign irq = |(isr & imr[EV_BITS-1:0]);
endmodule

// File: rtl/nand_bridge_strobe.sv
module nand_bridge_strobe
  import nand_bridge_pkg::*;
#(
  parameter int PULSE_CYC   = 3,
  parameter int RECOVER_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               wr,
  input  logic               wide,
  input  logic [HOST_DW-1:0] wdata,
  input  logic [NAND_DW-1:0] dq_in,
  output logic [NAND_DW-1:0] dq_out,
  output logic               dq_oe,
  output logic               we_n,
  output logic               re_n,
  output logic               busy,
  output logic               done,
  output logic [HOST_DW-1:0] rdata
);
  localparam int LANES = HOST_DW / NAND_DW;
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int MAXC  = (PULSE_CYC > RECOVER_CYC) ? PULSE_CYC : RECOVER_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  strobe_ph_e         ph;
  logic [CW-1:0]      cnt;
  logic [IW-1:0]      idx;
  logic               wr_q;
  logic               wide_q;
  logic [HOST_DW-1:0] wbuf;
  logic [HOST_DW-1:0] rbuf;
  logic               last;

  assign last = wide_q ? (idx == IW'(LANES - 1)) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      idx    <= '0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      wbuf   <= '0;
      rbuf   <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph     <= PH_LOW;
            cnt    <= CW'(PULSE_CYC - 1);
            idx    <= '0;
            wr_q   <= wr;
            wide_q <= wide;
            wbuf   <= wdata;
            rbuf   <= '0;
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            if (!wr_q) rbuf[idx*NAND_DW +: NAND_DW] <= dq_in;
            ph  <= PH_HIGH;
            cnt <= CW'(RECOVER_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            if (!last) begin
              idx <= idx + 1'b1;
              ph  <= PH_LOW;
              cnt <= CW'(PULSE_CYC - 1);
            end else begin
              ph <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign we_n   = !(ph == PH_LOW && wr_q);
  assign re_n   = !(ph == PH_LOW && !wr_q);
  assign dq_oe  = (ph != PH_IDLE) && wr_q;
  assign dq_out = wbuf[idx*NAND_DW +: NAND_DW];
  assign busy   = (ph != PH_IDLE);
  assign done   = (ph == PH_HIGH) && (cnt == '0) && last;
  assign rdata  = rbuf;
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nand_bridge_pkg::*;
#(
  parameter int PULSE_CYC   = 3,
  parameter int RECOVER_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req_valid,
  output logic                host_req_ready,
  input  logic                host_req_write,
  input  logic [HOST_AW-1:0]  host_req_addr,
  input  logic                host_req_wide,
  input  logic [HOST_DW-1:0]  host_req_wdata,
  output logic                host_rsp_valid,
  output logic [HOST_DW-1:0]  host_rsp_rdata,
  output logic                nand_ce_n,
  output logic                nand_cle,
  output logic                nand_ale,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic                nand_wp_n,
  output logic                nand_pwr_en,
  output logic [NAND_DW-1:0]  nand_dq_out,
  output logic                nand_dq_oe,
  input  logic [NAND_DW-1:0]  nand_dq_in,
  input  logic                nand_rb_n,
  output logic                irq
);
  logic               accept;
  logic               data_hit;
  logic               eng_start;
  logic               reg_wr;
  logic               eng_busy;
  logic               eng_done;
  logic [HOST_DW-1:0] eng_rdata;
  logic               rb_level;
  logic               rdy_rise;
  logic [7:0]         mode_q;
  logic [EV_BITS-1:0] isr_q;
  logic [7:0]         imr_q;
  logic [7:0]         reg_rd;

  assign host_req_ready = !eng_busy;
  assign accept    = host_req_valid && host_req_ready;
  assign data_hit  = (host_req_addr == OFS_DATA);
  assign eng_start = accept && data_hit;
  assign reg_wr    = accept && host_req_write && !data_hit;

  nand_bridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (nand_rb_n),
    .level    (rb_level),
    .rise     (rdy_rise)
  );

  nand_bridge_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (host_req_addr),
    .wdata    (host_req_wdata[7:0]),
    .rdy_rise (rdy_rise),
    .busy     (!rb_level),
    .mode     (mode_q),
    .isr      (isr_q),
    .imr      (imr_q),
    .rd_byte  (reg_rd),
    .irq      (irq)
  );

  nand_bridge_strobe #(
    .PULSE_CYC   (PULSE_CYC),
    .RECOVER_CYC (RECOVER_CYC)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (eng_start),
    .wr     (host_req_write),
    .wide   (host_req_wide),
    .wdata  (host_req_wdata),
    .dq_in  (nand_dq_in),
    .dq_out (nand_dq_out),
    .dq_oe  (nand_dq_oe),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .busy   (eng_busy),
    .done   (eng_done),
    .rdata  (eng_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rsp_valid <= 1'b0;
      host_rsp_rdata <= '0;
    end else begin
      host_rsp_valid <= (accept && !data_hit) || eng_done;
      if (eng_done)                 host_rsp_rdata <= eng_rdata;
      else if (accept && !data_hit) host_rsp_rdata <= {8'h00, reg_rd};
    end
  end

  assign nand_ce_n   = !mode_q[MB_CE];
  assign nand_cle    = mode_q[MB_CLE];
  assign nand_ale    = mode_q[MB_ALE];
  assign nand_wp_n   = mode_q[MB_WP];
  assign nand_pwr_en = mode_q[MB_PWR];
endmodule

// File: rtl/nand_bridge_checker.sv
module nand_bridge_checker
  import nand_bridge_pkg::*;
#(
  parameter int PULSE_CYC = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               nand_we_n,
  input logic               nand_re_n,
  input logic               nand_dq_oe,
  input logic               host_req_valid,
  input logic               host_req_ready,
  input logic               host_req_write,
  input logic [HOST_AW-1:0] host_req_addr,
  input logic [HOST_DW-1:0] host_req_wdata,
  input logic               host_rsp_valid,
  input logic               rdy_rise,
  input logic [EV_BITS-1:0] isr_q
);
  localparam int CW = $clog2(PULSE_CYC + 2) + 1;

  logic [CW-1:0] we_run;
  logic [CW-1:0] re_run;
  logic          acc;

  assign acc = host_req_valid && host_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      re_run <= '0;
    end else begin
      we_run <= !nand_we_n ? we_run + 1'b1 : '0;
      re_run <= !nand_re_n ? re_run + 1'b1 : '0;
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_run <= CW'(PULSE_CYC));

  assert_re_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    re_run <= CW'(PULSE_CYC));

  assert_data_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_req_addr == OFS_DATA) |=> !host_req_ready);

  assert_reg_response_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_req_addr != OFS_DATA) |=> host_rsp_valid);

  assert_ready_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_rise |=> isr_q[EV_READY]);

  assert_event_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_q[EV_READY]) |-> $past(rdy_rise));

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_req_write && host_req_addr == OFS_ISR &&
     host_req_wdata[EV_BITS-1:0] == '1 && !rdy_rise) |=> (isr_q == '0));
endmodule

bind nand_bridge nand_bridge_checker #(.PULSE_CYC(PULSE_CYC)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .nand_we_n      (nand_we_n),
  .nand_re_n      (nand_re_n),
  .nand_dq_oe     (nand_dq_oe),
  .host_req_valid (host_req_valid),
  .host_req_ready (host_req_ready),
  .host_req_write (host_req_write),
  .host_req_addr  (host_req_addr),
  .host_req_wdata (host_req_wdata),
  .host_rsp_valid (host_rsp_valid),
  .rdy_rise       (rdy_rise),
  .isr_q          (isr_q)
);

// File: tb/nand_bridge_bench.sv
module nand_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 3;
  localparam int RECOVER    = 2;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic        req_wide = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        ce_n, cle, ale, we_n, re_n, wp_n, pwr_en, dq_oe, irq;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in;
  logic        rb_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bridge #(.PULSE_CYC(PULSE), .RECOVER_CYC(RECOVER), .SYNC_STAGES(2)) u_nand_bridge (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(req_valid), .host_req_ready(req_ready),
    .host_req_write(req_write), .host_req_addr(req_addr),
    .host_req_wide(req_wide), .host_req_wdata(req_wdata),
    .host_rsp_valid(rsp_valid), .host_rsp_rdata(rsp_rdata),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_wp_n(wp_n),
    .nand_pwr_en(pwr_en), .nand_dq_out(dq_out), .nand_dq_oe(dq_oe),
    .nand_dq_in(dq_in), .nand_rb_n(rb_n), .irq(irq)
  );

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 37 + 5) & 8'hFF);
  endfunction

  function automatic logic [15:0] read_expect(input int n, input bit wide);
    return wide ? {pat(n + 1), pat(n)} : {8'h00, pat(n)};
  endfunction

  // flash pin monitor, samples at the falling clock edge
  logic [7:0] wbyte [0:1023];
  int         wwid  [0:1023];
  int         rwid  [0:1023];
  int wn = 0, rn = 0, we_w = 0, re_w = 0, overlap = 0, oe_bad = 0;
  logic [7:0] cur_byte;

  initial dq_in = pat(0);

  always @(negedge clk) begin
    if (!we_n && !re_n) overlap++;
    if (!we_n) begin
      we_w++;
      cur_byte = dq_out;
      if (!dq_oe) oe_bad++;
    end else if (we_w > 0) begin
      wbyte[wn] = cur_byte;
      wwid[wn]  = we_w;
      wn++;
      we_w = 0;
    end
    if (!re_n) begin
      re_w++;
    end else if (re_w > 0) begin
      rwid[rn] = re_w;
      rn++;
      dq_in = pat(rn);
      re_w = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [2:0] a, input bit wide, input logic [15:0] d,
                        output logic [15:0] rd, output bit stalled, output bit quick);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wide = wide; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    stalled = !req_ready;
    quick   = rsp_valid;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] v);
    logic [15:0] rd; bit s, q;
    access(1'b1, a, 1'b0, {8'h00, v}, rd, s, q);
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] v, input string rq);
    logic [15:0] rd; bit s, q;
    access(1'b0, a, 1'b0, 16'h0, rd, s, q);
    chk(q, rq, q, 1);
    v = rd[7:0];
  endtask

  task automatic data_write(input bit wide, input logic [15:0] d, input string rq);
    logic [15:0] rd; bit s, q;
    int base = wn;
    int nb = wide ? 2 : 1;
    access(1'b1, 3'd0, wide, d, rd, s, q);
    chk(wn - base == nb, rq, wn - base, nb);
    if (wide) chk(s, "R5 ready low during 16-bit write", s, 1);
    for (int i = 0; i < nb && i < wn - base; i++) begin
      chk(wbyte[base + i] == d[i*8 +: 8], rq, wbyte[base + i], d[i*8 +: 8]);
      chk(wwid[base + i] == PULSE, rq, wwid[base + i], PULSE);
    end
  endtask

  task automatic data_read(input bit wide, input string rq);
    logic [15:0] rd; bit s, q;
    int base = rn;
    int nb = wide ? 2 : 1;
    logic [15:0] exp = read_expect(base, wide);
    access(1'b0, 3'd0, wide, 16'h0, rd, s, q);
    chk(rn - base == nb, rq, rn - base, nb);
    chk(rd == exp, rq, rd, exp);
    for (int i = 0; i < nb && i < rn - base; i++)
      chk(rwid[base + i] == PULSE, rq, rwid[base + i], PULSE);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ce_n && !cle && !ale && !pwr_en && !wp_n && we_n && re_n && !irq,
        "R1 reset pins", {ce_n, cle, ale, pwr_en, wp_n, we_n, re_n, irq}, 8'b10000110);
    reg_read(3'd4, v, "R1 mode reset"); chk(v == 8'h00, "R1 mode reset", v, 0);

    // R3 power
    reg_write(3'd4, 8'h0C); @(negedge clk);
    chk(pwr_en == 1'b1, "R3 power on", pwr_en, 1);
    reg_write(3'd4, 8'h08); @(negedge clk);
    chk(pwr_en == 1'b0, "R3 power off", pwr_en, 0);

    // R2 phases, R4 command byte
    reg_write(3'd4, 8'h95); @(negedge clk);
    chk(!ce_n && cle && !ale && wp_n, "R2 command phase", {ce_n, cle, ale, wp_n}, 4'b0101);
    data_write(1'b0, 16'h00FF, "R4 command byte");
    reg_write(3'd4, 8'h96); @(negedge clk);
    chk(!ce_n && !cle && ale, "R2 address phase", {ce_n, cle, ale}, 3'b001);
    reg_write(3'd4, 8'h94); @(negedge clk);
    chk(!ce_n && !cle && !ale, "R2 data phase", {ce_n, cle, ale}, 3'b000);
    reg_read(3'd4, v, "R12 mode readback"); chk(v == 8'h94, "R12 mode readback", v, 8'h94);

    // R5 / R6 / R7
    data_write(1'b1, 16'hA55A, "R5 16-bit write order");
    data_read(1'b1, "R6 16-bit read order");
    data_read(1'b0, "R7 8-bit read");

    // R8 / R9 / R10
    @(negedge clk); rb_n = 1'b0; repeat (4) @(negedge clk);
    reg_read(3'd5, v, "R8 busy"); chk(v == 8'h80, "R8 busy", v, 8'h80);
    reg_read(3'd6, v, "R9 no event on fall"); chk(v == 8'h00, "R9 no event on fall", v, 0);
    rb_n = 1'b1; repeat (4) @(negedge clk);
    reg_read(3'd5, v, "R8 ready"); chk(v == 8'h00, "R8 ready", v, 0);
    reg_read(3'd6, v, "R9 event on rise"); chk(v == 8'h01, "R9 event on rise", v, 1);
    chk(irq == 1'b0, "R10 masked", irq, 0);
    reg_write(3'd7, 8'h81); @(negedge clk);
    chk(irq == 1'b1, "R10 enabled", irq, 1);
    reg_read(3'd7, v, "R12 mask readback"); chk(v == 8'h81, "R12 mask readback", v, 8'h81);
    reg_write(3'd6, 8'h0F); @(negedge clk);
    chk(irq == 1'b0, "R9 cleared irq", irq, 0);
    reg_read(3'd6, v, "R9 cleared"); chk(v == 8'h00, "R9 cleared", v, 0);
    @(negedge clk); rb_n = 1'b0; repeat (4) @(negedge clk); rb_n = 1'b1; repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R10 second event", irq, 1);
    reg_write(3'd7, 8'h00); @(negedge clk);
    chk(irq == 1'b0, "R10 mask off", irq, 0);
    reg_write(3'd6, 8'h0F);

    // random traffic
    for (int it = 0; it < 60; it++) begin
      int op = int'($urandom_range(0, 4));
      logic [15:0] d = 16'($urandom);
      case (op)
        0: data_write(1'b0, {8'h00, d[7:0]}, "R4 random byte write");
        1: data_write(1'b1, d, "R5 random word write");
        2: data_read(1'b0, "R7 random byte read");
        3: data_read(1'b1, "R6 random word read");
        default: begin
          reg_write(3'd4, d[7:0]);
          @(negedge clk);
          chk(ce_n == !d[4] && cle == d[0] && ale == d[1] && pwr_en == d[2],
              "R2 random mode pins", {ce_n, cle, ale, pwr_en}, {!d[4], d[0], d[1], d[2]});
          reg_read(3'd4, v, "R12 random mode");
          chk(v == d[7:0], "R12 random mode", v, d[7:0]);
        end
      endcase
    end

    chk(overlap == 0, "R11 strobe overlap", overlap, 0);
    chk(oe_bad == 0, "R11 drive during write", oe_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule